// File: doc/BRIEF.md
# DMA Event Latch and Request Controller

This block sits in front of a DMA transfer engine and turns synchronization events into transfer requests. Each of sixteen channels owns one pending bit. A one-cycle pulse on a channel's event input sets that bit, whatever the channel's enable state. A pending channel that is enabled raises a request toward the engine, and its bit clears when the engine acknowledges that request.

Software reaches the block through a small word-addressed register port. It can read the pending bits, read and write the per-channel enable mask, clear pending bits by writing ones, and raise pending bits by writing ones. A bit raised by software carries a hidden flag. That flag lets the channel request even while its enable bit is off, so software can start an unsynchronized transfer. A disabled channel that latched a hardware event keeps its bit until software clears it or the channel is enabled.

Only one request is outstanding at a time. The lowest-numbered requesting channel is chosen. The request and its channel number stay fixed until the engine acknowledges, and a new choice is made in the cycle after that.

Top module: `evt_req_ctrl`

## Requirements
- R1: After synchronous reset the pending bits, the enable mask and req_valid are all zero.
- R2: Register offsets are 0 for pending (read-only), 1 for enable (read/write), 2 for clear and 3 for set. Bits 31:16 of every read are zero, reads of offsets 2 and 3 return zero, and writes to offset 0 change nothing.
- R3: A high bit on evt_in sets that channel's pending bit at the next clock edge, whatever its enable. Further pulses while the bit is pending change nothing.
- R4: A pending channel whose enable bit is 0 and that was not raised by software never requests, and its bit stays set.
- R5: An enabled pending channel requests, and its pending bit is zero after the clock edge at which req_valid and req_ack are both high.
- R6: Writing to offset 2 clears each pending bit whose write-data bit is 1 and leaves bits written with 0 unchanged, for enabled and disabled channels alike.
- R7: Writing to offset 3 sets each pending bit whose write-data bit is 1. Such a channel requests and is served even while its enable bit is 0.
- R8: When several channels may request, the lowest-numbered one is chosen.
- R9: While req_valid is high and req_ack is low, req_valid stays high and req_chan does not change.
- R10: A set from evt_in or from a set write wins over a clear write or an acknowledge that hits the same bit in the same cycle, so the bit stays pending.
- R11: A disabled channel whose bit is pending is served once its enable bit is later written to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register word offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| evt_in | input | 16 | Per-channel event pulses |
| req_valid | output | 1 | Transfer request outstanding |
| req_chan | output | 4 | Channel number of the outstanding request |
| req_ack | input | 1 | Engine accepts the outstanding request |

## Verification
The case that matters most is a set landing on a bit in the same cycle that the bit is removed. The bench pulses an event on the granted channel in the very cycle it raises req_ack. It then expects the bit to remain pending and a second grant for that channel to appear in the scoreboard. In the same way, it drives a clear write and an event pulse on one disabled channel together, reads the pending register back, and expects the bit to still be set.

// File: rtl/evt_req_pkg.sv
package evt_req_pkg;

    localparam int NUM_CH = 16;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    typedef logic [NUM_CH-1:0] ch_mask_t;
    typedef logic [CH_W-1:0]   ch_idx_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_PEND = 2'd0,
        REG_ENA  = 2'd1,
        REG_CLR  = 2'd2,
        REG_SET  = 2'd3
    } reg_sel_e;

    // software commands decoded from one bus cycle
    typedef struct packed {
        ch_mask_t sw_set;
        ch_mask_t sw_clr;
    } sw_cmd_t;

    typedef struct packed {
        logic    valid;
        ch_idx_t chan;
    } req_t;

    function automatic ch_idx_t lowest_idx(ch_mask_t m);
        ch_idx_t r;
        r = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (m[i]) r = ch_idx_t'(i);
        end
        return r;
    endfunction

    function automatic ch_mask_t idx_onehot(ch_idx_t i);
        return ch_mask_t'(1) << i;
    endfunction

endpackage

// File: rtl/evt_csr.sv
module evt_csr
    import evt_req_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  ch_mask_t          pending,
    output ch_mask_t          enable,
    output sw_cmd_t           cmd,
    output logic [DATA_W-1:0] bus_rdata
);
    reg_sel_e sel;
    ch_mask_t wmask;
    logic     unused_wdata_hi;

    assign sel             = reg_sel_e'(bus_addr);
    assign wmask           = bus_wdata[NUM_CH-1:0];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_CH];

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '0;
        end else if (bus_wr && sel == REG_ENA) begin
            enable <= wmask;
        end
    end

    always_comb begin
        cmd.sw_set = (bus_wr && sel == REG_SET) ? wmask : '0;
        cmd.sw_clr = (bus_wr && sel == REG_CLR) ? wmask : '0;
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            REG_PEND: bus_rdata[NUM_CH-1:0] = pending;
            REG_ENA:  bus_rdata[NUM_CH-1:0] = enable;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/evt_pending_bank.sv
module evt_pending_bank
    import evt_req_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ch_mask_t hw_evt,
    input  sw_cmd_t  cmd,
    input  ch_mask_t submit,
    output ch_mask_t pending,
    output ch_mask_t sw_flag
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic set_any;
        logic drop;

        assign set_any = hw_evt[g] | cmd.sw_set[g];
        assign drop    = cmd.sw_clr[g] | submit[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                pending[g] <= 1'b0;
                sw_flag[g] <= 1'b0;
            end else begin
                pending[g] <= set_any | (pending[g] & ~drop);
                sw_flag[g] <= cmd.sw_set[g] | (sw_flag[g] & ~drop);
            end
        end
    end
endmodule

// File: rtl/evt_arbiter.sv
module evt_arbiter
    import evt_req_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ch_mask_t eligible,
    input  logic     ack,
    output req_t     req,
    output ch_mask_t submit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req <= '0;
        end else if (req.valid) begin
            if (ack) req.valid <= 1'b0;
        end else if (|eligible) begin
            req.valid <= 1'b1;
            req.chan  <= lowest_idx(eligible);
        end
    end

    assign submit = (req.valid && ack) ? idx_onehot(req.chan) : '0;
endmodule

// File: rtl/evt_req_ctrl.sv
module evt_req_ctrl
    import evt_req_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] evt_in,
    output logic              req_valid,
    output logic [CH_W-1:0]   req_chan,
    input  logic              req_ack
);
    ch_mask_t pending;
    ch_mask_t sw_flag;
    ch_mask_t enable;
    ch_mask_t eligible;
    ch_mask_t submit;
    sw_cmd_t  cmd;
    req_t     req;

    evt_csr u_csr (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .pending   (pending),
        .enable    (enable),
        .cmd       (cmd),
        .bus_rdata (bus_rdata)
    );

    evt_pending_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .hw_evt  (evt_in),
        .cmd     (cmd),
        .submit  (submit),
        .pending (pending),
        .sw_flag (sw_flag)
    );

    assign eligible = pending & (enable | sw_flag);

    evt_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .eligible (eligible),
        .ack      (req_ack),
        .req      (req),
        .submit   (submit)
    );

    assign req_valid = req.valid;
    assign req_chan  = req.chan;
endmodule

// File: rtl/evt_req_ctrl_chk.sv
module evt_req_ctrl_chk
    import evt_req_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_CH-1:0] evt_in,
    input logic              req_valid,
    input logic [CH_W-1:0]   req_chan,
    input logic              req_ack,
    input logic [NUM_CH-1:0] pending,
    input logic [NUM_CH-1:0] eligible
);
    ch_mask_t elig_q;
    ch_mask_t below;
    logic     set_on_chan;

    always_ff @(posedge clk) elig_q <= eligible;

    assign below       = (ch_mask_t'(1) << req_chan) - ch_mask_t'(1);
    assign set_on_chan = evt_in[req_chan] |
                         (bus_wr && bus_addr == REG_SET && bus_wdata[req_chan]);

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!req_valid && pending == '0));

    a_r2_rsv_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:NUM_CH] == '0);

    a_r2_wo_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == REG_CLR || bus_addr == REG_SET) |-> bus_rdata == '0);

    // R3 and R10: a hardware set always lands, whatever else hits the bit
    a_r3_evt_latched: assert property (@(posedge clk) disable iff (rst)
        (|evt_in) |=> ((pending & $past(evt_in)) == $past(evt_in)));

    // R7 and R10: a set write always lands
    a_r7_sw_set_latched: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_SET) |=>
        ((pending & $past(bus_wdata[NUM_CH-1:0])) == $past(bus_wdata[NUM_CH-1:0])));

    a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ack && !set_on_chan) |=> !pending[$past(req_chan)]);

    // R8 and R4: a new grant goes to an eligible channel with no eligible one below it
    a_r8_lowest_first: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> (elig_q[req_chan] && (elig_q & below) == '0));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_chan)));
endmodule

bind evt_req_ctrl evt_req_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_in    (evt_in),
    .req_valid (req_valid),
    .req_chan  (req_chan),
    .req_ack   (req_ack),
    .pending   (pending),
    .eligible  (eligible)
);

// File: tb/tb_evt_req_ctrl.sv
module tb_evt_req_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] evt_in = '0;
    logic        req_valid;
    logic [3:0]  req_chan;
    logic        req_ack = 1'b0;

    int checks = 0;
    int failures = 0;
    int exp_q[$];

    always #2 clk = ~clk;

    evt_req_ctrl dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
        .req_valid(req_valid), .req_chan(req_chan), .req_ack(req_ack)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: every accepted request is compared with the scoreboard
    always @(posedge clk) begin
        if (!rst && req_valid && req_ack) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R5 unexpected grant actual=0x%0h expected=none", req_chan);
            end else begin
                int e;
                e = exp_q.pop_front();
                checks++;
                if (int'(req_chan) != e) begin
                    failures++;
                    $display("FAIL R8 grant order actual=0x%0h expected=0x%0h", req_chan, e);
                end
            end
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic pulse(input logic [15:0] m);
        evt_in = m;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic wait_req();
        for (int i = 0; i < 20 && !req_valid; i++) @(negedge clk);
    endtask

    task automatic ack_one(input int exp, input string tag);
        wait_req();
        chk(req_valid == 1'b1, tag, req_valid, 1);
        chk(int'(req_chan) == exp, tag, req_chan, exp);
        exp_q.push_back(exp);
        req_ack = 1'b1;
        @(negedge clk);
        req_ack = 1'b0;
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1
        rd_chk(2'd0, 32'h0, "R1 pending after reset");
        rd_chk(2'd1, 32'h0, "R1 enable after reset");
        chk(req_valid == 1'b0, "R1 req_valid after reset", req_valid, 0);

        // R2
        reg_wr(2'd0, 32'hFFFF_FFFF);
        rd_chk(2'd0, 32'h0, "R2 pending ignores writes");
        reg_wr(2'd1, 32'hFFFF_0005);
        rd_chk(2'd1, 32'h0000_0005, "R2 reserved enable bits read zero");
        rd_chk(2'd2, 32'h0, "R2 clear reads zero");
        rd_chk(2'd3, 32'h0, "R2 set reads zero");
        reg_wr(2'd1, 32'h0);

        // R3 / R4
        pulse(16'h0010);
        cyc(3);
        rd_chk(2'd0, 32'h0010, "R3 disabled event latched");
        chk(req_valid == 1'b0, "R4 disabled channel idle", req_valid, 0);
        pulse(16'h0010);
        cyc(1);
        rd_chk(2'd0, 32'h0010, "R3 repeat pulse no effect");

        // R6
        reg_wr(2'd2, 32'h0000_0000);
        rd_chk(2'd0, 32'h0010, "R6 clear with zero keeps bit");
        reg_wr(2'd2, 32'h0000_0010);
        rd_chk(2'd0, 32'h0, "R6 clear with one drops bit");

        // R11 / R5
        pulse(16'h0008);
        cyc(2);
        chk(req_valid == 1'b0, "R4 still idle before enable", req_valid, 0);
        reg_wr(2'd1, 32'h0000_0008);
        ack_one(3, "R11 late enable serves channel");
        rd_chk(2'd0, 32'h0, "R5 pending clears on ack");

        // R7
        reg_wr(2'd1, 32'h0);
        reg_wr(2'd3, 32'h0000_0100);
        rd_chk(2'd0, 32'h0100, "R7 set write raises pending");
        ack_one(8, "R7 forced channel served while disabled");
        rd_chk(2'd0, 32'h0, "R7 forced bit clears on ack");

        // R8
        reg_wr(2'd1, 32'h0000_00FF);
        pulse(16'h00A4);
        ack_one(2, "R8 lowest first");
        ack_one(5, "R8 second");
        ack_one(7, "R8 third");
        rd_chk(2'd0, 32'h0, "R8 all served");

        // R9
        pulse(16'h0002);
        wait_req();
        pulse(16'h0001);
        for (int i = 0; i < 4; i++) begin
            chk(req_valid && req_chan == 4'd1, "R9 request held",
                {req_valid, req_chan}, 5'h11);
            cyc(1);
        end
        ack_one(1, "R9 held channel granted");
        ack_one(0, "R9 next channel");

        // R10: event on the acknowledged channel in the same cycle
        reg_wr(2'd1, 32'h0000_0040);
        pulse(16'h0040);
        wait_req();
        chk(req_chan == 4'd6, "R10 setup grant", req_chan, 6);
        exp_q.push_back(6);
        req_ack = 1'b1;
        evt_in = 16'h0040;
        @(negedge clk);
        req_ack = 1'b0;
        evt_in = '0;
        rd_chk(2'd0, 32'h0040, "R10 set beats submission");
        ack_one(6, "R10 channel requests again");

        // R10: event and clear write on one disabled channel
        reg_wr(2'd1, 32'h0);
        evt_in = 16'h0200;
        reg_wr(2'd2, 32'h0000_0200);
        evt_in = '0;
        rd_chk(2'd0, 32'h0200, "R10 set beats clear write");
        reg_wr(2'd2, 32'h0000_0200);
        rd_chk(2'd0, 32'h0, "R6 clear on disabled channel");

        cyc(3);
        chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
        chk(req_valid == 1'b0, "R4 idle at end", req_valid, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule